// File: doc/BRIEF.md
# Binary FSK Tone-Energy Detector

This block turns a stream of signed real samples into a binary FSK decision by watching how much energy sits at each of two tones: the mark tone (bit 1) and the space tone (bit 0). Each tone has its own phase accumulator. The phase drives a pair of quadrature references, one sine-like and one cosine-like. The input is mixed with both references, and each of the four products feeds a boxcar averager. The averager keeps a running sum over the last 2^K accepted samples, so each tone behaves like a single-bin DFT that updates on every sample. The squared magnitudes of the two tones are subtracted. The difference is the soft output, and its sign gives the hard bit.

The references are ternary, taking the values +1, 0 or -1, and are chosen by the top two phase bits. The mixer therefore reduces to a selector that passes the sample, zero, or the negated sample. This reference is exact when a tone sits at a quarter of the sample rate. An optional clipping mode replaces each sample by a full-scale value carrying the sample's sign. The hard bit holds its previous value when the two energies are equal. No result is flagged valid until the averaging window has filled once after reset. Symbol timing and frequency-offset correction are left to downstream logic.

Top module: `fsk_tone_detector`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `out_valid`, `bit_out` and `soft_out` are all zero.
- R2: Each tone's phase starts at 0 after reset and advances by that tone's increment on every accepted sample. The reference for a sample comes from the top two bits of the phase before that sample's advance: 00 gives sin +1 / cos 0, 01 gives sin 0 / cos +1, 10 gives sin -1 / cos 0, and 11 gives sin 0 / cos -1. An increment of one quarter of the phase range therefore produces the sine sequence 1, 0, -1, 0.
- R3: For each tone, the in-phase sum is the total of sample×sin-reference over the last N = 2^K accepted samples, and the quadrature sum is the same total using the cos-reference. Samples from before reset count as zero. The tone energy is I² + Q².
- R4: On every `out_valid` cycle, `soft_out` equals the mark energy minus the space energy as a signed value.
- R5: On a valid result, `bit_out` is 1 if the mark energy exceeds the space energy and 0 if it is lower. On a tie, `bit_out` keeps its previous value.
- R6: `out_valid` is high for one cycle, two rising edges after the edge that accepts a sample. This happens only once at least N samples have been accepted since reset. Before that, an accepted sample yields no valid result.
- R7: When `clip_en` is high, a sample is replaced by +(2^(SW-1)-1) if it is zero or positive and by -(2^(SW-1)-1) if it is negative, before mixing.
- R8: While `in_valid` is low, `out_valid` stays low and `soft_out` and `bit_out` hold their values.
- R9: A window full of the most negative sample, mixed by -1, or a window full of full-scale samples of the same sign, is summed and squared exactly without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SW | Signed input sample |
| clip_en | input | 1 | Reduce each sample to its signed full-scale value |
| inc_mark | input | PW | Phase increment of the mark (bit 1) tone |
| inc_space | input | PW | Phase increment of the space (bit 0) tone |
| out_valid | output | 1 | Soft and hard outputs updated this cycle |
| soft_out | output | 2*(SW+K)+1 | Signed mark-minus-space energy |
| bit_out | output | 1 | Hard decision, held on a tie |

## Verification
The assertions assume that `in_valid` is low while reset is held, so the fill count begins at zero. They also assume that `rst_n` is held long enough to clear the whole delay line. The timing checks take the two-edge latency from acceptance to result as fixed, whether the strobe comes in bursts or with gaps. The stimulus respects these assumptions: it drives every input half a cycle away from the active edge and keeps the strobe low during reset. Its random samples, increments and clipping choices all stay inside the declared port widths, including the most negative sample value.

// File: rtl/fsk_tone_detector.sv
module fsk_tone_detector #(
  parameter int SW = 12,
  parameter int PW = 24,
  parameter int K  = 4,
  localparam int EW = 2 * (SW + K)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  input  logic                 clip_en,
  input  logic [PW-1:0]        inc_mark,
  input  logic [PW-1:0]        inc_space,
  output logic                 out_valid,
  output logic signed [EW:0]   soft_out,
  output logic                 bit_out
);
  localparam int N    = 1 << K;
  localparam int PRW  = SW + 1;
  localparam int SUMW = SW + K + 1;
  localparam logic signed [PRW-1:0] FSV = PRW'((1 << (SW - 1)) - 1);

  logic [PW-1:0] ph_mark, ph_space;
  logic [K:0]    fill;
  logic          upd_q;
  logic signed [PRW-1:0]  xs;
  logic signed [SUMW-1:0] acc_w [4];

  assign xs = clip_en ? (in_sample[SW-1] ? -FSV : FSV) : PRW'(in_sample);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_mark  <= '0;
      ph_space <= '0;
      fill     <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= in_valid;
      if (in_valid) begin
        ph_mark  <= ph_mark + inc_mark;
        ph_space <= ph_space + inc_space;
        if (fill != (K+1)'(N)) fill <= fill + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : lane
    localparam bit IS_COS = g[0];
    logic [1:0] q;
    logic signed [PRW-1:0]  prod;
    logic signed [PRW-1:0]  tap [N];
    logic signed [SUMW-1:0] acc;

    assign q = (g < 2) ? ph_mark[PW-1 -: 2] : ph_space[PW-1 -: 2];

    always_comb begin
      prod = '0;
      if (IS_COS) begin
        if (q == 2'd1) prod = xs;
        else if (q == 2'd3) prod = -xs;
      end else begin
        if (q == 2'd0) prod = xs;
        else if (q == 2'd2) prod = -xs;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= '0;
        for (int i = 0; i < N; i++) tap[i] <= '0;
      end else if (in_valid) begin
        tap[0] <= prod;
        for (int i = 1; i < N; i++) tap[i] <= tap[i-1];
        acc <= acc + SUMW'(prod) - SUMW'(tap[N-1]);
      end
    end

    assign acc_w[g] = acc;
  end

  function automatic logic [EW-1:0] sq(input logic signed [SUMW-1:0] v);
    logic signed [EW-1:0] w;
    w = EW'(v);
    return EW'(w * w);
  endfunction

  logic [EW-1:0]      e_mark, e_space;
  logic signed [EW:0] diff;

  assign e_mark  = sq(acc_w[0]) + sq(acc_w[1]);
  assign e_space = sq(acc_w[2]) + sq(acc_w[3]);
  assign diff    = $signed({1'b0, e_mark}) - $signed({1'b0, e_space});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      soft_out  <= '0;
      bit_out   <= 1'b0;
    end else begin
      out_valid <= upd_q && (fill == (K+1)'(N));
      if (upd_q && (fill == (K+1)'(N))) begin
        soft_out <= diff;
        if (diff > 0) bit_out <= 1'b1;
        else if (diff < 0) bit_out <= 1'b0;
      end
    end
  end
endmodule

module fsk_tone_detector_chk #(
  parameter int K  = 4,
  parameter int EW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic signed [EW:0] soft_out,
  input logic               bit_out
);
  localparam int N = 1 << K;
  logic [K:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != (K+1)'(N)) seen <= seen + 1'b1;
  end

  assert_fill_before_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen == (K+1)'(N));
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(soft_out) && $stable(bit_out)));
  assert_bit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && soft_out > 0) |-> bit_out);
  assert_bit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && soft_out < 0) |-> !bit_out);
  assert_tie_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && soft_out == 0) |-> $stable(bit_out));
endmodule

bind fsk_tone_detector fsk_tone_detector_chk #(.K(K), .EW(EW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .soft_out(soft_out), .bit_out(bit_out)
);

// File: tb/fsk_tone_detector_test.sv
module fsk_tone_detector_test;
  localparam int SW = 12;
  localparam int PW = 24;
  localparam int K  = 4;
  localparam int N  = 1 << K;
  localparam int EW = 2 * (SW + K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic clip_en = 1'b0;
  logic [PW-1:0] inc_mark = '0, inc_space = '0;
  logic out_valid;
  logic signed [EW:0] soft_out;
  logic bit_out;

  fsk_tone_detector #(.SW(SW), .PW(PW), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .clip_en(clip_en), .inc_mark(inc_mark), .inc_space(inc_space),
    .out_valid(out_valid), .soft_out(soft_out), .bit_out(bit_out)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  int unsigned m_ph_m, m_ph_s;
  longint hist [4][N];
  int hp, accepted;
  bit exp_bit;
  longint exp_soft;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refv(input int unsigned ph, input bit cosarm);
    int q = int'((ph >> (PW - 2)) & 3);
    if (!cosarm) return (q == 0) ? 1 : (q == 2) ? -1 : 0;
    return (q == 1) ? 1 : (q == 3) ? -1 : 0;
  endfunction

  function automatic longint lanesum(input int g);
    longint s = 0;
    for (int i = 0; i < N; i++) s += hist[g][i];
    return s;
  endfunction

  task automatic model_clear();
    m_ph_m = 0; m_ph_s = 0; hp = 0; accepted = 0;
    exp_bit = 0; exp_soft = 0;
    for (int g = 0; g < 4; g++) for (int i = 0; i < N; i++) hist[g][i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    model_clear();
    chk(out_valid == 0 && bit_out == 0 && soft_out == 0, "R1 reset held", soft_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && bit_out == 0 && soft_out == 0, "R1 after reset", soft_out, 0);
  endtask

  task automatic apply(input int xi, input bit clip, input int unsigned im, input int unsigned is);
    longint xv, e1, e0;
    @(negedge clk);
    in_valid = 1; in_sample = SW'(xi); clip_en = clip;
    inc_mark = PW'(im); inc_space = PW'(is);
    @(negedge clk);
    in_valid = 0;
    xv = clip ? ((xi < 0) ? -2047 : 2047) : longint'(xi);
    hist[0][hp] = xv * refv(m_ph_m, 0);
    hist[1][hp] = xv * refv(m_ph_m, 1);
    hist[2][hp] = xv * refv(m_ph_s, 0);
    hist[3][hp] = xv * refv(m_ph_s, 1);
    hp = (hp + 1) % N;
    m_ph_m = (m_ph_m + im) & 32'hFFFFFF;
    m_ph_s = (m_ph_s + is) & 32'hFFFFFF;
    if (accepted < N) accepted++;
    @(negedge clk);
    if (accepted == N) begin
      e1 = lanesum(0) * lanesum(0) + lanesum(1) * lanesum(1);
      e0 = lanesum(2) * lanesum(2) + lanesum(3) * lanesum(3);
      exp_soft = e1 - e0;
      if (e1 > e0) exp_bit = 1;
      else if (e1 < e0) exp_bit = 0;
      chk(out_valid == 1, "R6 valid after fill", out_valid, 1);
      chk(longint'(soft_out) == exp_soft, "R3/R4 soft energy difference", longint'(soft_out), exp_soft);
      chk(bit_out == exp_bit, "R5 hard bit", bit_out, exp_bit);
    end else begin
      chk(out_valid == 0, "R6 no valid before fill", out_valid, 0);
      chk(bit_out == exp_bit, "R5 bit before fill", bit_out, exp_bit);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    int unsigned im, is;
    seed = int'($urandom(32'h5EED));
    do_reset();

    // R2: mark at quarter rate, matching 1,0,-1,0 pattern
    for (int n = 0; n < 3 * N; n++) begin
      int pat [4] = '{900, 0, -900, 0};
      apply(pat[n % 4], 0, 32'h400000, 32'h200000);
    end
    chk(bit_out == 1, "R2 quarter-rate mark detected", bit_out, 1);
    chk(longint'(soft_out) == longint'(N / 2 * 900) * (N / 2 * 900),
        "R2 quarter-rate mark energy", longint'(soft_out), longint'(N / 2 * 900) * (N / 2 * 900));

    // R5: silence gives a tie, bit must hold 1
    for (int n = 0; n < 2 * N; n++) apply(0, 0, 32'h400000, 32'h200000);
    chk(bit_out == 1 && soft_out == 0, "R5 tie holds previous bit", bit_out, 1);

    // R8: idle strobe holds everything
    repeat (6) @(negedge clk);
    chk(out_valid == 0 && bit_out == 1 && soft_out == 0, "R8 idle hold", soft_out, 0);

    // space tone at eighth rate
    for (int n = 0; n < 3 * N; n++) begin
      int pat [8] = '{700, 700, 0, 0, -700, -700, 0, 0};
      apply(pat[n % 8], 0, 32'h400000, 32'h200000);
    end
    chk(bit_out == 0, "R5 space tone gives 0", bit_out, 0);

    // R9: most negative sample, mark steady, space alternating
    do_reset();
    for (int n = 0; n < N; n++) apply(-2048, 0, 0, 32'h800000);
    chk(longint'(soft_out) == (longint'(1) << 30), "R9 full-scale window exact",
        longint'(soft_out), longint'(1) << 30);

    // R7: clipping of small samples to signed full scale
    do_reset();
    for (int n = 0; n < N; n++) apply((n % 2) ? -5 : 3, 1, 0, 32'h800000);
    chk(longint'(soft_out) == -(longint'(N) * 2047) * (N * 2047), "R7 clipped samples",
        longint'(soft_out), -(longint'(N) * 2047) * (N * 2047));

    // random mix with mid-run resets (R6 refill)
    im = 32'h400000; is = 32'h200000;
    for (int n = 0; n < 2000; n++) begin
      int xi;
      if (n % 64 == 0) begin
        im = $urandom() & 32'hFFFFFF;
        is = $urandom() & 32'hFFFFFF;
      end
      if (n % 700 == 699) do_reset();
      case ($urandom_range(9))
        0: xi = -2048;
        1: xi = 2047;
        2: xi = 0;
        default: xi = int'($urandom_range(4095)) - 2048;
      endcase
      apply(xi, ($urandom_range(3) == 0), im, is);
      if ($urandom_range(7) == 0) repeat ($urandom_range(3)) @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule